// File: doc/BRIEF.md
# Flag-Setting Integer ALU Stage

This block is one pipeline stage of an integer datapath. It takes a first operand, a second operand chosen from a register value or an immediate, a 3-bit operation code and the current carry and overflow status bits. It returns a result word, a fresh N/Z/C/V flag vector and two write enables. The write enables tell the register file whether to keep the result and the status register whether to keep the flags. The arithmetic is combinational. It is followed by a single output register that carries a valid/ready handshake on both sides.

Supported operations are plain add, add-with-carry, subtract-with-carry, AND, bit-clear and a multiply that keeps only the low word. Each operation follows its own rule for updating the flags. Plain add behaves like a compare: it writes the flags but never the result. Back-pressure rules: a beat is accepted on any rising edge where `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, every output stays frozen and no new beat is taken.

Top module: `alu_flag_stage`

## Requirements
- R1: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_result`, `out_flags`, `out_flag_we` and `out_res_we` stay unchanged. `in_ready` is 1 whenever `out_valid` is 0 or `out_ready` is 1.
- R2: A beat accepted at a rising edge appears on the outputs with `out_valid` = 1 straight after that edge. With `in_valid` low and `out_ready` high, `out_valid` drops after the next edge.
- R3: Opcode 0 (add) gives a = low word of the 33-bit sum a+b, C = bit 32 of that sum, and V = 1 when a and b share a sign bit that differs from the result's bit 31. It sets `out_flag_we` = 1 and `out_res_we` = 0.
- R4: Opcode 1 (add-with-carry) adds `in_c` to the second operand first, in 33 bits, and then follows the R3 rules on that sum. The V rule uses bit 31 of (b + `in_c`). Both write enables are 1.
- R5: Opcode 2 (subtract-with-carry) forms m = two's complement of the low word of (b + `in_c`) and computes a + m. Result and C are bits 31:0 and bit 32 of that sum. V follows the R3 rule with m in place of b. Both write enables are 1.
- R6: The flag vector is ordered N = bit 3, Z = bit 2, C = bit 1, V = bit 0. For every defined opcode, N = result bit 31 and Z = 1 exactly when the result is zero.
- R7: Opcode 3 (a AND b) and opcode 4 (a AND NOT b) force C and V to 0. Both write enables are 1.
- R8: Opcode 5 (multiply) returns the low 32 bits of a*b and passes `in_c` and `in_v` through as C and V. Both write enables are 1.
- R9: When `in_use_imm` is 1, `in_imm` replaces `in_b` as the second operand, and `in_b` has no effect on the outputs.
- R10: Opcodes 6 and 7 give a zero result, zero flags and both write enables 0.
- R11: During and after reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Stage can take a beat |
| in_op | input | 3 | Operation code |
| in_a | input | 32 | First operand |
| in_b | input | 32 | Register second operand |
| in_imm | input | 32 | Immediate second operand |
| in_use_imm | input | 1 | Select the immediate as second operand |
| in_c | input | 1 | Current carry flag |
| in_v | input | 1 | Current overflow flag |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Consumer takes the output beat |
| out_result | output | 32 | Result word |
| out_flags | output | 4 | N, Z, C, V (bits 3..0) |
| out_flag_we | output | 1 | Flags should be written |
| out_res_we | output | 1 | Result should be written |

## Verification
Each opcode is run on operand pairs chosen to tell its rules apart. For add, the pairs cover a carry-out that wraps to zero, signed overflow into a negative result, and the case where both carry and overflow fire at once. For the carry forms, the same operands are run with the carry clear and set. An all-ones operand with a set carry probes the 33-bit addend. A subtraction of zero probes the zero-carry rule. Logic and multiply cases are run with C and V already set, which shows the difference between forcing those flags to zero and passing them through. Immediate beats carry a decoy register operand, and a stall sequence holds the output while a different beat waits at the input.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int unsigned OP_W = 3;
  localparam logic [OP_W-1:0] OP_ADD = 3'd0;
  localparam logic [OP_W-1:0] OP_ADC = 3'd1;
  localparam logic [OP_W-1:0] OP_SBC = 3'd2;
  localparam logic [OP_W-1:0] OP_AND = 3'd3;
  localparam logic [OP_W-1:0] OP_BIC = 3'd4;
  localparam logic [OP_W-1:0] OP_MUL = 3'd5;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } alu_flags_t;
endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] reg_val,
  input  logic [W-1:0] imm_val,
  input  logic         use_imm,
  output logic [W-1:0] opnd
);
  // The immediate arrives already confined to the datapath width.
  assign opnd = use_imm ? imm_val : reg_val;
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         negate,
  output logic [W-1:0] sum,
  output logic         carry,
  output logic         ovf
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W:0]   b_plus;
  logic [W-1:0] b_neg;
  logic [W:0]   addend;
  logic [W:0]   total;

  // Carry is folded into the operand first, keeping its wrap bit.
  assign b_plus = {1'b0, b} + {{W{1'b0}}, cin};
  assign b_neg  = (~b_plus[W-1:0]) + ONE;
  assign addend = negate ? {1'b0, b_neg} : b_plus;
  assign total  = {1'b0, a} + addend;

  assign sum   = total[W-1:0];
  assign carry = total[W];
  assign ovf   = (a[W-1] == addend[W-1]) && (addend[W-1] != total[W-1]);
endmodule

// File: rtl/alu_bitwise.sv
module alu_bitwise #(
  parameter int unsigned W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] and_res,
  output logic [W-1:0] bic_res,
  output logic [W-1:0] mul_res
);
  assign and_res = a & b;
  assign bic_res = a & ~b;
  // Only the low word of the product is kept.
  assign mul_res = a * b;
endmodule

// File: rtl/alu_flag_stage.sv
module alu_flag_stage
  import alu_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [OP_W-1:0] in_op,
  input  logic [W-1:0]    in_a,
  input  logic [W-1:0]    in_b,
  input  logic [W-1:0]    in_imm,
  input  logic            in_use_imm,
  input  logic            in_c,
  input  logic            in_v,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [W-1:0]    out_result,
  output logic [3:0]      out_flags,
  output logic            out_flag_we,
  output logic            out_res_we
);
  localparam int unsigned MSB = W - 1;

  logic [W-1:0] opnd_b;
  logic [W-1:0] as_sum;
  logic         as_c;
  logic         as_v;
  logic         as_cin;
  logic         as_neg;
  logic [W-1:0] and_res;
  logic [W-1:0] bic_res;
  logic [W-1:0] mul_res;

  logic [W-1:0] nx_res;
  alu_flags_t   nx_flags;
  logic         nx_fwe;
  logic         nx_rwe;

  alu_operand_sel #(.W(W)) u_sel (
    .reg_val (in_b),
    .imm_val (in_imm),
    .use_imm (in_use_imm),
    .opnd    (opnd_b)
  );

  assign as_cin = in_c && ((in_op == OP_ADC) || (in_op == OP_SBC));
  assign as_neg = (in_op == OP_SBC);

  alu_addsub #(.W(W)) u_addsub (
    .a      (in_a),
    .b      (opnd_b),
    .cin    (as_cin),
    .negate (as_neg),
    .sum    (as_sum),
    .carry  (as_c),
    .ovf    (as_v)
  );

  alu_bitwise #(.W(W)) u_bitwise (
    .a       (in_a),
    .b       (opnd_b),
    .and_res (and_res),
    .bic_res (bic_res),
    .mul_res (mul_res)
  );

  always_comb begin
    nx_res   = '0;
    nx_flags = '0;
    nx_fwe   = 1'b1;
    nx_rwe   = 1'b1;
    unique case (in_op)
      OP_ADD, OP_ADC, OP_SBC: begin
        nx_res     = as_sum;
        nx_flags.c = as_c;
        nx_flags.v = as_v;
        nx_rwe     = (in_op != OP_ADD);
      end
      OP_AND: nx_res = and_res;
      OP_BIC: nx_res = bic_res;
      OP_MUL: begin
        nx_res     = mul_res;
        nx_flags.c = in_c;
        nx_flags.v = in_v;
      end
      default: begin
        nx_fwe = 1'b0;
        nx_rwe = 1'b0;
      end
    endcase
    if (nx_fwe) begin
      nx_flags.n = nx_res[MSB];
      nx_flags.z = (nx_res == '0);
    end
  end

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_flags   <= '0;
      out_flag_we <= 1'b0;
      out_res_we  <= 1'b0;
    end else if (in_valid && in_ready) begin
      out_valid   <= 1'b1;
      out_result  <= nx_res;
      out_flags   <= nx_flags;
      out_flag_we <= nx_fwe;
      out_res_we  <= nx_rwe;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/alu_flag_stage_chk.sv
module alu_flag_stage_chk #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_result,
  input logic [3:0]   out_flags,
  input logic         out_flag_we,
  input logic         out_res_we
);
  // R1
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) &&
      $stable(out_flags) && $stable(out_flag_we) && $stable(out_res_we)));

  // R1
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R2
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R6
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_we) |-> (out_flags[2] == (out_result == '0)));

  // R6
  neg_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_flag_we) |-> (out_flags[3] == out_result[W-1]));

  // R3
  res_implies_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_res_we) |-> out_flag_we);

  // R10
  unused_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_flag_we) |-> (!out_res_we && out_result == '0 && out_flags == 4'd0));
endmodule

bind alu_flag_stage alu_flag_stage_chk #(.W(W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_result  (out_result),
  .out_flags   (out_flags),
  .out_flag_we (out_flag_we),
  .out_res_we  (out_res_we)
);

// File: tb/test_alu_flag_stage.sv
module test_alu_flag_stage;
  typedef struct packed {
    logic [3:0]  req;
    logic [2:0]  op;
    logic        use_imm;
    logic        c;
    logic        v;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] imm;
    logic [31:0] res;
    logic [3:0]  flg;
    logic        fwe;
    logic        rwe;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd3,  3'd0, 1'b0, 1'b0, 1'b0, 32'h1,        32'h2,        32'h0,  32'h3,        4'h0, 1'b1, 1'b0}, // R3
    '{4'd3,  3'd0, 1'b0, 1'b0, 1'b0, 32'h7FFFFFFF, 32'h1,        32'h0,  32'h80000000, 4'h9, 1'b1, 1'b0}, // R3
    '{4'd6,  3'd0, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h1,        32'h0,  32'h0,        4'h6, 1'b1, 1'b0}, // R6
    '{4'd3,  3'd0, 1'b0, 1'b0, 1'b0, 32'h80000000, 32'h80000000, 32'h0,  32'h0,        4'h7, 1'b1, 1'b0}, // R3
    '{4'd4,  3'd1, 1'b0, 1'b1, 1'b0, 32'h5,        32'h6,        32'h0,  32'hC,        4'h0, 1'b1, 1'b1}, // R4
    '{4'd4,  3'd1, 1'b0, 1'b0, 1'b0, 32'h5,        32'h6,        32'h0,  32'hB,        4'h0, 1'b1, 1'b1}, // R4
    '{4'd4,  3'd1, 1'b0, 1'b1, 1'b0, 32'h3,        32'hFFFFFFFF, 32'h0,  32'h3,        4'h2, 1'b1, 1'b1}, // R4
    '{4'd5,  3'd2, 1'b0, 1'b0, 1'b0, 32'hA,        32'h3,        32'h0,  32'h7,        4'h2, 1'b1, 1'b1}, // R5
    '{4'd5,  3'd2, 1'b0, 1'b1, 1'b0, 32'hA,        32'h3,        32'h0,  32'h6,        4'h2, 1'b1, 1'b1}, // R5
    '{4'd5,  3'd2, 1'b0, 1'b0, 1'b0, 32'h3,        32'hA,        32'h0,  32'hFFFFFFF9, 4'h8, 1'b1, 1'b1}, // R5
    '{4'd5,  3'd2, 1'b0, 1'b0, 1'b0, 32'h0,        32'h0,        32'h0,  32'h0,        4'h4, 1'b1, 1'b1}, // R5
    '{4'd5,  3'd2, 1'b0, 1'b0, 1'b0, 32'h80000000, 32'h1,        32'h0,  32'h7FFFFFFF, 4'h3, 1'b1, 1'b1}, // R5
    '{4'd7,  3'd3, 1'b0, 1'b1, 1'b1, 32'hF0F0F0F0, 32'hFF00FF00, 32'h0,  32'hF000F000, 4'h8, 1'b1, 1'b1}, // R7
    '{4'd7,  3'd3, 1'b0, 1'b1, 1'b1, 32'h0F0F,     32'hF0F0,     32'h0,  32'h0,        4'h4, 1'b1, 1'b1}, // R7
    '{4'd7,  3'd4, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h0000FFFF, 32'h0,  32'hFFFF0000, 4'h8, 1'b1, 1'b1}, // R7
    '{4'd8,  3'd5, 1'b0, 1'b1, 1'b1, 32'h00010000, 32'h00010000, 32'h0,  32'h0,        4'h7, 1'b1, 1'b1}, // R8
    '{4'd8,  3'd5, 1'b0, 1'b0, 1'b0, 32'hFFFFFFFF, 32'h2,        32'h0,  32'hFFFFFFFE, 4'h8, 1'b1, 1'b1}, // R8
    '{4'd8,  3'd5, 1'b0, 1'b1, 1'b0, 32'h7,        32'h6,        32'h0,  32'h2A,       4'h2, 1'b1, 1'b1}, // R8
    '{4'd9,  3'd0, 1'b1, 1'b0, 1'b0, 32'h1,        32'h1234,     32'h10, 32'h11,       4'h0, 1'b1, 1'b0}, // R9
    '{4'd9,  3'd3, 1'b1, 1'b0, 1'b0, 32'h1234,     32'h0,        32'hFF, 32'h34,       4'h0, 1'b1, 1'b1}, // R9
    '{4'd10, 3'd6, 1'b0, 1'b0, 1'b0, 32'h5,        32'h5,        32'h0,  32'h0,        4'h0, 1'b0, 1'b0}, // R10
    '{4'd10, 3'd7, 1'b0, 1'b1, 1'b1, 32'hFFFFFFFF, 32'h1,        32'h0,  32'h0,        4'h0, 1'b0, 1'b0}  // R10
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = 3'd0;
  logic [31:0] in_a = '0;
  logic [31:0] in_b = '0;
  logic [31:0] in_imm = '0;
  logic        in_use_imm = 1'b0;
  logic        in_c = 1'b0;
  logic        in_v = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_flags;
  logic        out_flag_we;
  logic        out_res_we;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  alu_flag_stage i_alu_flag_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_a(in_a), .in_b(in_b), .in_imm(in_imm),
    .in_use_imm(in_use_imm), .in_c(in_c), .in_v(in_v),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_flags(out_flags), .out_flag_we(out_flag_we), .out_res_we(out_res_we)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(input vec_t t);
    in_op = t.op; in_use_imm = t.use_imm; in_c = t.c; in_v = t.v;
    in_a = t.a; in_b = t.b; in_imm = t.imm;
  endtask

  function automatic logic [63:0] packed_out(input logic [31:0] r, input logic [3:0] f,
                                             input logic fw, input logic rw, input logic vl);
    return {25'd0, vl, fw, rw, f, r};
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (2) @(negedge clk);
    check("R11 reset valid/ready", {62'd0, out_valid, in_ready}, 64'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R11 after reset valid/ready", {62'd0, out_valid, in_ready}, 64'd1);

    // Table walk, back-to-back beats.
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      in_valid = 1'b1;
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            packed_out(out_result, out_flags, out_flag_we, out_res_we, out_valid),
            packed_out(VECS[i].res, VECS[i].flg, VECS[i].fwe, VECS[i].rwe, 1'b1));
    end

    // R2: drain with no new input.
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 drain", {63'd0, out_valid}, 64'd0);

    // R1: back-pressure holds the output while another beat waits.
    out_ready = 1'b0;
    drive(VECS[0]);
    in_valid = 1'b1;
    @(negedge clk);
    check("R1 stalled ready", {62'd0, out_valid, in_ready}, 64'd2);
    drive(VECS[4]);
    repeat (2) @(negedge clk);
    check("R1 held output", packed_out(out_result, out_flags, out_flag_we, out_res_we, out_valid),
          packed_out(32'h3, 4'h0, 1'b1, 1'b0, 1'b1));
    out_ready = 1'b1;
    @(negedge clk);
    check("R2 released beat", packed_out(out_result, out_flags, out_flag_we, out_res_we, out_valid),
          packed_out(32'hC, 4'h0, 1'b1, 1'b1, 1'b1));

    // R9: register operand ignored under immediate select.
    in_op = 3'd0; in_use_imm = 1'b1; in_a = 32'h2; in_imm = 32'h3; in_b = 32'hFFFF0000;
    in_c = 1'b0; in_v = 1'b0;
    @(negedge clk);
    check("R9 decoy register", {32'd0, out_result}, 64'h5);
    in_valid = 1'b0;
    @(negedge clk);
    check("R2 final drain", {63'd0, out_valid}, 64'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule